// File: doc/BRIEF.md
# Outstanding Response Tracker with Completion Queue

This block follows one outstanding coherence miss. When the cache sends a read or exclusive request, the tracker is armed. Its count then starts at the number of parties that must answer: every other last-level cache plus memory. Each arriving response lowers the count by the acknowledgement weight it carries. Two single-step inputs, one that lowers the count by one and one that raises it by one, cover protocol corner cases, such as an ownership hand-off that adds one expected message. A sticky flag records whether any responder said it still holds a shared copy.

When an accepted update leaves the count at zero, the tracker produces one completion trigger. Its kind says whether sharers were seen. The trigger goes into a small in-order queue, and the controller drains that queue with a pop strobe. The tracker rejects malformed or out-of-range updates and reports them on one-cycle error pulses. Releasing the tracker clears it.

Top module: `pend_resp_tracker`

## Requirements
- R1: After reset the count is 0, the sharer flag is 0, the tracker is idle, the queue is empty and both error pulses are low.
- R2: An allocate loads the count with LOAD_VAL (default 4), clears the sharer flag, marks the tracker busy and re-arms completion, all on the next clock edge. Allocate takes priority over every other input in the same cycle.
- R3: While busy, one edge applies a response weight (subtracted), a step-down (subtract 1) and a step-up (add 1) together, all from the same cycle.
- R4: A response carrying weight 0 is ignored: it changes neither the count nor the sharer flag, and bad_ack_o pulses for one cycle after that edge.
- R5: An update whose result would fall below 0 or exceed 2^CNT_W-1 is discarded as a whole, and range_err_o pulses for one cycle.
- R6: An accepted response with the shared bit set sets the sharer flag. The flag stays set until the next allocate or release.
- R7: When an accepted update leaves the count at 0, one trigger is queued. Its kind is 1 (all acks, sharers seen) if the sharer flag including this update is set, and 0 (all acks, no sharers) otherwise.
- R8: At most one trigger is produced per allocation, even if the count leaves zero and returns to it.
- R9: A release clears the count and the sharer flag and makes the tracker idle. While idle, responses and step inputs have no effect and raise no error.
- R10: The queue returns triggers in arrival order. trig_kind_o shows the head entry while trig_valid_o is high. A pop removes the head, and a pop on an empty queue is ignored.
- R11: A trigger produced while the queue holds Q_DEPTH entries (default 4) and no pop occurs is discarded, and the queued entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Request issued: arm tracker and load count |
| release_i | input | 1 | Transaction retired: clear and idle |
| resp_valid_i | input | 1 | A response arrives this cycle |
| resp_acks_i | input | ACK_W | Acknowledgement weight of the response |
| resp_shared_i | input | 1 | Responder keeps a shared copy |
| step_dn_i | input | 1 | Lower the count by one |
| step_up_i | input | 1 | Raise the count by one |
| trig_pop_i | input | 1 | Consume the head trigger |
| trig_valid_o | output | 1 | Queue holds at least one trigger |
| trig_kind_o | output | 1 | Head trigger kind: 1 sharers seen, 0 none |
| count_o | output | CNT_W | Messages still expected |
| sharers_o | output | 1 | Sticky sharer flag |
| busy_o | output | 1 | Tracker armed |
| range_err_o | output | 1 | Pulse: update rejected as out of range |
| bad_ack_o | output | 1 | Pulse: response with zero weight |

## Verification
The hardest state to reach from the ports is a full queue that then receives one more trigger. Reaching it takes several complete allocate-to-zero cycles with no pops in between. A directed sequence builds it from back-to-back allocations, each finished by one response of weight 4, with the shared bit alternating so that the drained order can be checked. A second hard case is a count that returns to zero after it has already fired. A directed step-up followed by a step-down creates it. Random traffic, with rare allocates and releases and occasional zero-weight responses, then mixes underflow, late responses and pops on an empty queue.

// File: rtl/trk_pkg.sv
package trk_pkg;
    typedef enum logic {
        TRIG_NO_SHARERS = 1'b0,
        TRIG_ALL_ACKS   = 1'b1
    } trig_kind_e;
endpackage

// File: rtl/pend_count_core.sv
module pend_count_core
    import trk_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int ACK_W    = 3,
    parameter int LOAD_VAL = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             release_i,
    input  logic             resp_valid_i,
    input  logic [ACK_W-1:0] resp_acks_i,
    input  logic             resp_shared_i,
    input  logic             step_dn_i,
    input  logic             step_up_i,
    output logic [CNT_W-1:0] count_o,
    output logic             sharers_o,
    output logic             busy_o,
    output logic             range_err_o,
    output logic             bad_ack_o,
    output logic             fire_o,
    output trig_kind_e       fire_kind_o
);
    // Two guard bits: the top one flags a negative result, the next one overflow.
    localparam int SUM_W = CNT_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sharers;
        logic             busy;
        logic             fired;
        logic             range_err;
        logic             bad_ack;
    } core_state_t;

    core_state_t      st_q, st_d;
    logic [SUM_W-1:0] sum;
    logic             acks_ok, upd, neg, ovf, shr_next;
    logic             fire;
    trig_kind_e       kind;

    always_comb begin
        st_d           = st_q;
        st_d.range_err = 1'b0;
        st_d.bad_ack   = 1'b0;
        fire           = 1'b0;
        kind           = TRIG_NO_SHARERS;
        acks_ok  = resp_valid_i && (resp_acks_i != '0);
        sum      = SUM_W'(st_q.cnt)
                 - (acks_ok ? SUM_W'(resp_acks_i) : SUM_W'(0))
                 - SUM_W'(step_dn_i)
                 + SUM_W'(step_up_i);
        neg      = sum[SUM_W-1];
        ovf      = !neg && (sum[SUM_W-2:CNT_W] != '0);
        upd      = acks_ok || step_dn_i || step_up_i;
        shr_next = st_q.sharers | (acks_ok & resp_shared_i);

        if (alloc_i) begin
            st_d.cnt     = CNT_W'(LOAD_VAL);
            st_d.sharers = 1'b0;
            st_d.busy    = 1'b1;
            st_d.fired   = 1'b0;
        end else if (release_i) begin
            st_d.cnt     = '0;
            st_d.sharers = 1'b0;
            st_d.busy    = 1'b0;
            st_d.fired   = 1'b0;
        end else if (st_q.busy) begin
            if (resp_valid_i && (resp_acks_i == '0)) begin
                st_d.bad_ack = 1'b1;
            end
            if (upd) begin
                if (neg || ovf) begin
                    st_d.range_err = 1'b1;
                end else begin
                    st_d.cnt     = sum[CNT_W-1:0];
                    st_d.sharers = shr_next;
                    if ((sum == '0) && !st_q.fired) begin
                        fire       = 1'b1;
                        kind       = shr_next ? TRIG_ALL_ACKS : TRIG_NO_SHARERS;
                        st_d.fired = 1'b1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o     = st_q.cnt;
    assign sharers_o   = st_q.sharers;
    assign busy_o      = st_q.busy;
    assign range_err_o = st_q.range_err;
    assign bad_ack_o   = st_q.bad_ack;
    assign fire_o      = fire;
    assign fire_kind_o = kind;

    // R2: allocate arms the tracker with the full expected count
    a_r2_alloc_loads: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |=> (st_q.cnt == CNT_W'(LOAD_VAL)) && !st_q.sharers && st_q.busy);

    // R9: release empties the tracker
    a_r9_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (release_i && !alloc_i) |=> (st_q.cnt == '0) && !st_q.sharers && !st_q.busy);

    // R6: the sharer flag only falls on allocate or release
    a_r6_sharers_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sharers && !alloc_i && !release_i) |=> st_q.sharers);

    // R5: a rejected update leaves the count untouched
    a_r5_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        range_err_o |-> (st_q.cnt == $past(st_q.cnt)));

    // R7: a trigger is only produced as the count settles at zero
    a_r7_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (st_q.cnt == '0));
endmodule

// File: rtl/trig_queue.sv
module trig_queue
    import trk_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  trig_kind_e push_kind_i,
    input  logic       pop_i,
    output logic       valid_o,
    output logic       kind_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0] slots;
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [OCC_W-1:0] occ;
    } q_state_t;

    q_state_t q_q, q_d;
    logic     pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d     = q_q;
        pop_ok  = pop_i && (q_q.occ != '0);
        push_ok = push_i && ((q_q.occ != OCC_W'(DEPTH)) || pop_ok);
        if (pop_ok) begin
            q_d.rd = bump(q_q.rd);
        end
        if (push_ok) begin
            q_d.slots[q_q.wr] = push_kind_i;
            q_d.wr            = bump(q_q.wr);
        end
        q_d.occ = q_q.occ + OCC_W'(push_ok) - OCC_W'(pop_ok);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign valid_o = (q_q.occ != '0);
    assign kind_o  = q_q.slots[q_q.rd];

    // R10: occupancy never exceeds the storage
    a_r10_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.occ <= OCC_W'(DEPTH));

    // R10: popping an empty queue leaves it empty
    a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && (q_q.occ == '0)) |=> (q_q.occ == '0));

    // R11: a push into a full queue without a pop changes nothing
    a_r11_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && (q_q.occ == OCC_W'(DEPTH)))
        |=> ((q_q.occ == OCC_W'(DEPTH)) && $stable(q_q.slots) && $stable(q_q.rd)));
endmodule

// File: rtl/pend_resp_tracker.sv
module pend_resp_tracker
    import trk_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int ACK_W    = 3,
    parameter int LOAD_VAL = 4,
    parameter int Q_DEPTH  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             release_i,
    input  logic             resp_valid_i,
    input  logic [ACK_W-1:0] resp_acks_i,
    input  logic             resp_shared_i,
    input  logic             step_dn_i,
    input  logic             step_up_i,
    input  logic             trig_pop_i,
    output logic             trig_valid_o,
    output logic             trig_kind_o,
    output logic [CNT_W-1:0] count_o,
    output logic             sharers_o,
    output logic             busy_o,
    output logic             range_err_o,
    output logic             bad_ack_o
);
    logic       fire;
    trig_kind_e fire_kind;

    pend_count_core #(
        .CNT_W   (CNT_W),
        .ACK_W   (ACK_W),
        .LOAD_VAL(LOAD_VAL)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .alloc_i      (alloc_i),
        .release_i    (release_i),
        .resp_valid_i (resp_valid_i),
        .resp_acks_i  (resp_acks_i),
        .resp_shared_i(resp_shared_i),
        .step_dn_i    (step_dn_i),
        .step_up_i    (step_up_i),
        .count_o      (count_o),
        .sharers_o    (sharers_o),
        .busy_o       (busy_o),
        .range_err_o  (range_err_o),
        .bad_ack_o    (bad_ack_o),
        .fire_o       (fire),
        .fire_kind_o  (fire_kind)
    );

    trig_queue #(
        .DEPTH(Q_DEPTH)
    ) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (fire),
        .push_kind_i(fire_kind),
        .pop_i      (trig_pop_i),
        .valid_o    (trig_valid_o),
        .kind_o     (trig_kind_o)
    );

    // R9: an idle tracker holds a zero count
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (count_o == '0));

    // R7: the cycle after a trigger is produced the queue is non-empty
    a_r7_fire_queued: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> trig_valid_o);
endmodule

// File: tb/pend_resp_tracker_tb_top.sv
module pend_resp_tracker_tb_top;
    localparam int CNT_W = 4;
    localparam int ACK_W = 3;
    localparam int LOADV = 4;
    localparam int QD    = 4;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_i = 0, release_i = 0, resp_valid_i = 0, resp_shared_i = 0;
    logic [ACK_W-1:0] resp_acks_i = '0;
    logic             step_dn_i = 0, step_up_i = 0, trig_pop_i = 0;
    logic             trig_valid_o, trig_kind_o, sharers_o, busy_o, range_err_o, bad_ack_o;
    logic [CNT_W-1:0] count_o;

    int checks = 0;
    int errors = 0;

    // Reference state
    int m_cnt = 0;
    bit m_sh = 0, m_act = 0, m_fired = 0, e_rerr = 0, e_bad = 0;
    bit mq[$];

    always #2 clk = ~clk;

    pend_resp_tracker #(
        .CNT_W(CNT_W), .ACK_W(ACK_W), .LOAD_VAL(LOADV), .Q_DEPTH(QD)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .release_i(release_i),
        .resp_valid_i(resp_valid_i), .resp_acks_i(resp_acks_i),
        .resp_shared_i(resp_shared_i), .step_dn_i(step_dn_i), .step_up_i(step_up_i),
        .trig_pop_i(trig_pop_i), .trig_valid_o(trig_valid_o), .trig_kind_o(trig_kind_o),
        .count_o(count_o), .sharers_o(sharers_o), .busy_o(busy_o),
        .range_err_o(range_err_o), .bad_ack_o(bad_ack_o)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of one clock edge, per the requirements
    task automatic model_edge(input bit a, input bit d, input bit rv, input int acks,
                              input bit sh, input bit dn, input bit up, input bit pp);
        bit ok, pushv, pk, popok;
        int nv, oldsz;
        bit nsh;
        e_rerr = 0; e_bad = 0; pushv = 0; pk = 0;
        if (a) begin
            m_cnt = LOADV; m_sh = 0; m_act = 1; m_fired = 0;
        end else if (d) begin
            m_cnt = 0; m_sh = 0; m_act = 0; m_fired = 0;
        end else if (m_act) begin
            ok = rv && (acks != 0);
            if (rv && acks == 0) e_bad = 1;
            if (ok || dn || up) begin
                nv  = m_cnt - (ok ? acks : 0) - int'(dn) + int'(up);
                nsh = m_sh | (ok && sh);
                if (nv < 0 || nv > MAXC) begin
                    e_rerr = 1;
                end else begin
                    m_cnt = nv; m_sh = nsh;
                    if (nv == 0 && !m_fired) begin
                        pushv = 1; pk = nsh; m_fired = 1;
                    end
                end
            end
        end
        oldsz = mq.size();
        popok = pp && (oldsz > 0);
        if (popok) void'(mq.pop_front());
        if (pushv && (oldsz < QD || popok)) mq.push_back(pk);
    endtask

    task automatic compare_all();
        check_eq("R3 count", int'(count_o), m_cnt);
        check_eq("R6 sharers", int'(sharers_o), int'(m_sh));
        check_eq("R9 busy", int'(busy_o), int'(m_act));
        check_eq("R5 range_err", int'(range_err_o), int'(e_rerr));
        check_eq("R4 bad_ack", int'(bad_ack_o), int'(e_bad));
        check_eq("R7 trig_valid", int'(trig_valid_o), int'(mq.size() > 0));
        if (mq.size() > 0) check_eq("R10 trig_kind", int'(trig_kind_o), int'(mq[0]));
    endtask

    task automatic cycle(input bit a, input bit d, input bit rv, input int acks,
                         input bit sh, input bit dn, input bit up, input bit pp);
        alloc_i = a; release_i = d; resp_valid_i = rv; resp_acks_i = ACK_W'(acks);
        resp_shared_i = sh; step_dn_i = dn; step_up_i = up; trig_pop_i = pp;
        model_edge(a, d, rv, acks, sh, dn, up, pp);
        @(posedge clk);
        #1;
        alloc_i = 0; release_i = 0; resp_valid_i = 0; resp_acks_i = '0;
        resp_shared_i = 0; step_dn_i = 0; step_up_i = 0; trig_pop_i = 0;
        compare_all();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        checks++;
        errors++;
        $display("FAIL R9 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7391));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_eq("R1 count", int'(count_o), 0);
        check_eq("R1 busy", int'(busy_o), 0);
        check_eq("R1 trig_valid", int'(trig_valid_o), 0);
        check_eq("R1 errors", int'(range_err_o) + int'(bad_ack_o), 0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;

        // R2/R3/R7: four unit acks, no sharers -> kind 0
        cycle(1,0,0,0,0,0,0,0);
        check_eq("R2 load", int'(count_o), 4);
        cycle(0,0,1,1,0,0,0,0);
        cycle(0,0,1,1,0,0,0,0);
        cycle(0,0,1,1,0,0,0,0);
        check_eq("R3 count after three", int'(count_o), 1);
        cycle(0,0,1,1,0,0,0,0);
        check_eq("R7 trigger queued", int'(trig_valid_o), 1);
        check_eq("R7 kind no sharers", int'(trig_kind_o), 0);
        // R8: leave zero and come back, no second trigger; pop the first
        cycle(0,0,0,0,0,0,1,1);
        check_eq("R10 popped", int'(trig_valid_o), 0);
        cycle(0,0,0,0,0,1,0,0);
        check_eq("R8 no refire", int'(trig_valid_o), 0);
        check_eq("R8 count zero", int'(count_o), 0);

        // R6/R7: shared response, then last response in same cycle as step-up/down
        cycle(1,1,1,3,0,0,0,0);
        check_eq("R2 alloc wins", int'(count_o), 4);
        cycle(0,0,1,2,1,0,0,0);
        check_eq("R6 flag set", int'(sharers_o), 1);
        // R4: zero weight ignored
        cycle(0,0,1,0,0,0,0,0);
        check_eq("R4 bad pulse", int'(bad_ack_o), 1);
        check_eq("R4 count held", int'(count_o), 2);
        // R5: 2 - 3 underflow
        cycle(0,0,1,3,0,0,0,0);
        check_eq("R5 underflow pulse", int'(range_err_o), 1);
        check_eq("R5 count held", int'(count_o), 2);
        cycle(0,0,1,2,0,1,1,0);
        check_eq("R7 kind all acks", int'(trig_kind_o), 1);
        cycle(0,0,0,0,0,0,0,1);

        // R9: release, then inputs ignored
        cycle(1,0,0,0,0,0,0,0);
        cycle(0,1,0,0,0,0,0,0);
        cycle(0,0,1,4,1,1,0,0);
        check_eq("R9 idle ignore", int'(count_o) + int'(sharers_o) + int'(range_err_o), 0);

        // R11: five completions, no pops; fifth discarded
        for (int i = 0; i < 5; i++) begin
            cycle(1,0,0,0,0,0,0,0);
            cycle(0,0,1,4,(i % 2 == 0),0,0,0);
        end
        for (int i = 0; i < 4; i++) begin
            check_eq("R11 order kind", int'(trig_kind_o), (i % 2 == 0) ? 1 : 0);
            cycle(0,0,0,0,0,0,0,1);
        end
        check_eq("R11 fifth dropped", int'(trig_valid_o), 0);
        cycle(0,0,0,0,0,0,0,1);
        check_eq("R10 pop empty", int'(trig_valid_o), 0);

        // Random traffic
        for (int n = 0; n < 4000; n++) begin
            bit a, d, rv, sh, dn, up, pp;
            int acks;
            a  = ($urandom_range(0, 15) == 0);
            d  = ($urandom_range(0, 31) == 0);
            rv = ($urandom_range(0, 2) == 0);
            acks = ($urandom_range(0, 7) == 0) ? 0 : $urandom_range(1, 3);
            sh = ($urandom_range(0, 3) == 0);
            dn = ($urandom_range(0, 7) == 0);
            up = ($urandom_range(0, 7) == 0);
            pp = ($urandom_range(0, 2) == 0);
            cycle(a, d, rv, acks, sh, dn, up, pp);
        end
        finish_run();
    end
endmodule